// File: doc/BRIEF.md
# Packed-Lane Immediate Logical Right Shifter

This block takes one 32-bit vector-shift instruction word and one packed source vector. It decodes the word and shifts every lane of the vector right by an immediate count. Zeros fill each lane from its most significant end. The lane width and the shift count are both encoded in one 7-bit combined immediate. The block recovers the lane width from the highest set bit of a 4-bit size field. It then takes the count as twice that width minus the 7-bit immediate.

The block sits in place of a register-file read and write. The caller supplies the source vector with a valid strobe. One clock later the block returns the shifted vector, the two register indices taken from the word, and a flag for an undefined instruction. Every lane is always processed, and the latency does not depend on the data.

Top module: `packed_lane_shifter`

## Requirements
- R1: A word is a recognised shift only when bits 31:24 equal 8'h04, bit 21 is 1 and bits 15:10 equal 6'b100101. Any other word accepted with a valid strobe sets the undefined flag.
- R2: The size field is {bits 23:22, bits 20:19}. A size value of 4'b0000 sets the undefined flag even when the opcode bits match.
- R3: The lane width is 8, 16, 32 or 64 bits when the highest set bit of the size field is bit 0, 1, 2 or 3 respectively.
- R4: The shift count is 2*laneWidth minus the unsigned 7-bit value {size, bits 18:16}. It lies between 1 and the lane width.
- R5: Each lane is shifted right by the count on its own, with zeros entering at the top and no bits crossing lanes. A count equal to the lane width yields an all-zero lane.
- R6: For an accepted word, srcIdx shows bits 9:5 and dstIdx shows bits 4:0.
- R7: outValid is high in the cycle after a cycle with inValid high and low after a cycle with inValid low.
- R8: When the undefined flag is set, the result vector is all zeros.
- R9: While rstN is low at a rising edge, the valid flag, the undefined flag and the result are cleared, whatever the inputs are.
- R10: The result and the register indices hold their values through cycles without a valid strobe. The undefined flag reads 0 in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Instruction and vector are presented this cycle |
| insn | input | 32 | Instruction word |
| srcVec | input | VEC_W | Packed source vector |
| outValid | output | 1 | Result registered from the previous cycle is valid |
| outUndef | output | 1 | Accepted word was undefined |
| srcIdx | output | 5 | Source register index |
| dstIdx | output | 5 | Destination register index |
| resVec | output | VEC_W | Shifted vector |

## Verification
The bench sweeps every size and immediate pair, so it reaches the count equal to the lane width in every lane format. A design that used the low set bit of the size field, or subtracted from the width instead of twice the width, would return wrong lanes there. All-ones operands expose any carry of bits between neighbouring lanes and any fill with ones instead of zeros. Words with size zero and words with each opcode region altered must raise the flag with a zero result. Idle cycles and reset with a strobe applied catch a register that loads without a strobe.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int NUM_SIZES = 4;
  localparam int SEL_W     = 2;
  localparam int AMT_W     = 7;
  localparam int IDX_W     = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             undef;
    logic [SEL_W-1:0] laneSel;
    logic [AMT_W-1:0] shiftAmt;
  } ctrl_t;

  function automatic logic [SEL_W-1:0] topBit(input logic [3:0] v);
    if (v[3])      return 2'd3;
    else if (v[2]) return 2'd2;
    else if (v[1]) return 2'd1;
    else           return 2'd0;
  endfunction
endpackage

// File: rtl/lsr_control.sv
module lsr_control
  import lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      insn,
  output ctrl_t            ctrl,
  output logic             outValid,
  output logic             outUndef,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx
);
  logic             opMatch;
  logic [3:0]       sizeField;
  logic [2:0]       immLow;
  logic [7:0]       twiceWidth;
  logic [7:0]       amtFull;
  logic             isUndef;

  always_comb begin
    opMatch    = (insn[31:24] == 8'h04) && insn[21] && (insn[15:10] == 6'b100101);
    sizeField  = {insn[23:22], insn[20:19]};
    immLow     = insn[18:16];
    isUndef    = !opMatch || (sizeField == 4'b0000);
    twiceWidth = 8'd16 << topBit(sizeField);
    amtFull    = twiceWidth - {1'b0, sizeField, immLow};
    ctrl.load     = inValid;
    ctrl.undef    = isUndef;
    ctrl.laneSel  = topBit(sizeField);
    ctrl.shiftAmt = amtFull[AMT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outUndef <= 1'b0;
    end else begin
      outValid <= inValid;
      outUndef <= inValid && isUndef;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && inValid) begin
      srcIdx <= insn[9:5];
      dstIdx <= insn[4:0];
    end
  end

  // R7 valid follows strobe by one cycle
  a_r7_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2 zero size always flags
  a_r2_size_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && insn[23:22] == 2'b00 && insn[20:19] == 2'b00) |=> outUndef);
  // R4 decoded count in range for a defined word
  a_r4_shift_range: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isUndef) |-> (ctrl.shiftAmt >= 7'd1 &&
      ctrl.shiftAmt <= (7'd8 << ctrl.laneSel)));
endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [VEC_W-1:0] srcVec,
  output logic [VEC_W-1:0] resVec
);
  logic [NUM_SIZES-1:0][VEC_W-1:0] bySize;
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign bySize[s][l*LW +: LW] = srcVec[l*LW +: LW] >> ctrl.shiftAmt;
    end
  end

  always_comb nextRes = ctrl.undef ? '0 : bySize[ctrl.laneSel];

  always_ff @(posedge clk) begin
    if (!rstN)          resVec <= '0;
    else if (ctrl.load) resVec <= nextRes;
  end

  // R10 result holds without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(resVec));
  // R8 undefined word produces zero
  a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.undef) |=> (resVec == '0));
endmodule

// File: rtl/packed_lane_shifter.sv
module packed_lane_shifter
  import lsr_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      insn,
  input  logic [VEC_W-1:0] srcVec,
  output logic             outValid,
  output logic             outUndef,
  output logic [4:0]       srcIdx,
  output logic [4:0]       dstIdx,
  output logic [VEC_W-1:0] resVec
);
  ctrl_t ctrl;

  initial assert (VEC_W % 64 == 0 && VEC_W >= 64);

  lsr_control u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn), .ctrl(ctrl),
    .outValid(outValid), .outUndef(outUndef), .srcIdx(srcIdx), .dstIdx(dstIdx)
  );

  lsr_datapath #(.VEC_W(VEC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcVec(srcVec), .resVec(resVec)
  );

  // R8 flagged output carries zero result
  a_r8_flag_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUndef) |-> (resVec == '0));
endmodule

// File: tb/packed_lane_shifter_bench.sv
`timescale 1ns/1ps
module packed_lane_shifter_bench;
  localparam int VEC_W = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rstN, inValid;
  logic [31:0]      insn;
  logic [VEC_W-1:0] srcVec;
  logic             outValid, outUndef;
  logic [4:0]       srcIdx, dstIdx;
  logic [VEC_W-1:0] resVec;

  packed_lane_shifter #(.VEC_W(VEC_W)) u_packed_lane_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn), .srcVec(srcVec),
    .outValid(outValid), .outUndef(outUndef), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .resVec(resVec)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  logic             expValid = 0, expUndef = 0;
  logic [4:0]       expSrc = '0, expDst = '0;
  logic [VEC_W-1:0] expRes = '0;

  function automatic logic [31:0] mk(input logic [3:0] sz, input logic [2:0] im,
                                     input logic [4:0] zn, input logic [4:0] zd);
    return {8'h04, sz[3:2], 1'b1, sz[1:0], im, 6'b100101, zn, zd};
  endfunction

  function automatic logic [VEC_W-1:0] refShift(input int esize, input int sh,
                                                input logic [VEC_W-1:0] v);
    logic [VEC_W-1:0] r;
    for (int i = 0; i < VEC_W; i++) begin
      int pos = i % esize;
      r[i] = (pos + sh < esize) ? v[i+sh] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic cycle(input logic r, input logic v, input logic [31:0] w,
                       input logic [VEC_W-1:0] vec, input string tag);
    rstN = r; inValid = v; insn = w; srcVec = vec;
    if (!r) begin
      expValid = 0; expUndef = 0; expRes = '0;
    end else if (v) begin
      logic [3:0] sz = {w[23:22], w[20:19]};
      bit match = (w[31:24] == 8'h04) && w[21] && (w[15:10] == 6'b100101);
      bit und = !match || (sz == 0);
      expValid = 1; expUndef = und; expSrc = w[9:5]; expDst = w[4:0];
      if (und) expRes = '0;
      else begin
        int hb = 0, es, sh;
        for (int b = 0; b < 4; b++) if (sz[b]) hb = b;
        es = 8 << hb;
        sh = 2 * es - int'({sz, w[18:16]});
        expRes = refShift(es, sh, vec);
      end
    end else begin
      expValid = 0; expUndef = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(outValid == expValid, {tag, " R7 valid"}, VEC_W'(outValid), VEC_W'(expValid));
    check(outUndef == expUndef, {tag, " undef"}, VEC_W'(outUndef), VEC_W'(expUndef));
    check(resVec == expRes, {tag, " result"}, resVec, expRes);
    if (r) begin
      check(srcIdx == expSrc, {tag, " R6 srcIdx"}, VEC_W'(srcIdx), VEC_W'(expSrc));
      check(dstIdx == expDst, {tag, " R6 dstIdx"}, VEC_W'(dstIdx), VEC_W'(expDst));
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; inValid = 0; insn = '0; srcVec = '0;
    @(negedge clk);
    // R9 reset wins over a strobe
    cycle(0, 1, mk(4'b0001, 3'd0, 5'd1, 5'd2), '1, "R9 reset");
    cycle(0, 1, mk(4'b1000, 3'd7, 5'd3, 5'd4), '1, "R9 reset");
    // R3 R4 R5 full sweep of size and immediate
    for (int s = 1; s < 16; s++) begin
      for (int m = 0; m < 8; m++) begin
        cycle(1, 1, mk(4'(s), 3'(m), 5'($urandom), 5'($urandom)), rnd(), "R3 R4 sweep");
        cycle(1, 1, mk(4'(s), 3'(m), 5'($urandom), 5'($urandom)), '1, "R5 ones");
      end
    end
    // R10 hold through idle cycles with changing inputs
    cycle(1, 1, mk(4'b0010, 3'd3, 5'd9, 5'd17), rnd(), "R10 load");
    for (int k = 0; k < 4; k++)
      cycle(1, 0, mk(4'b0001, 3'd0, 5'd0, 5'd0), rnd(), "R10 idle");
    // R2 size zero
    for (int m = 0; m < 8; m++)
      cycle(1, 1, mk(4'b0000, 3'(m), 5'd5, 5'd6), '1, "R2 R8 size0");
    // R1 opcode mismatches
    cycle(1, 1, mk(4'b0100, 3'd1, 5'd7, 5'd8) & ~32'h0020_0000, '1, "R1 R8 bit21");
    cycle(1, 1, mk(4'b0100, 3'd1, 5'd7, 5'd8) ^ 32'h0100_0000, '1, "R1 R8 top");
    cycle(1, 1, mk(4'b0100, 3'd1, 5'd7, 5'd8) ^ 32'h0000_0400, '1, "R1 R8 mid");
    cycle(1, 1, mk(4'b0100, 3'd1, 5'd7, 5'd8) ^ 32'h0000_8000, '1, "R1 R8 mid");
    cycle(1, 1, mk(4'b1111, 3'd7, 5'd31, 5'd0), '1, "R4 min shift");
    cycle(1, 0, '0, '0, "R7 idle");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule